// File: doc/BRIEF.md
# Priority-Level Interrupt Controller with Mask

The block gathers sixteen interrupt sources into one request toward the CPU. Sources 0 to 7 are external IRQ lines, each gated by a bit of a software enable register. Sources 8 to 15 are internal, each gated by its own enable input. Every source has a 3-bit priority level, stored two to a byte in eight priority registers. On every clock the block finds the pending source with the highest level and compares that level with the CPU's 3-bit mask. Only a level strictly above the mask raises the request.

Software programs the levels and the external enables through a simple write/read port: a write strobe, an address, write data and a combinational read-data output. A hardware-standby input clears the external enable register. Software standby needs no input of its own, because the enable register keeps its contents on every cycle that has no reset, hardware standby or write to it. The request, the winning source number and the winning level are registered outputs.

Top module: `prio_irq_ctrl`

## Requirements
- R1: Priority register k (address k, 0..7) holds the level of source 2k in bits 6:4 and the level of source 2k+1 in bits 2:0. Bits 7 and 3 read as 0, and data written to them is ignored.
- R2: After reset all priority registers and the enable register (address 8) read 0x00, and req_o, req_idx_o and req_lvl_o are 0.
- R3: A source is pending when its line is high and its enable is set. An external line n uses irq_ext_i[n] and enable bit n. Internal source 8+m uses int_src_i[m] and int_en_i[m]. Among the pending sources, the one with the highest level is selected, with 7 highest and 0 lowest.
- R4: When several pending sources share the highest level, the lowest-numbered source wins.
- R5: req_o is 1 only when the selected level is strictly greater than mask_i. A source at level 0 therefore never raises a request.
- R6: The outputs reflect the inputs and register contents sampled at the previous rising clock edge. While req_o is 0, req_idx_o and req_lvl_o are 0.
- R7: In the enable register at address 8, bit n enables external line n (1 = enabled). A disabled line is never selected.
- R8: While hw_stby_i is high, the enable register is cleared on each clock and writes to it are ignored. The priority registers keep their values. The enable register stays 0 after standby ends until it is rewritten.
- R9: The enable register keeps its value across any number of cycles without reset, hardware standby or a write to address 8. Writes to other addresses do not change it.
- R10: Addresses 9 to 15 read 0x00, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| hw_stby_i | input | 1 | Hardware standby; clears the external enable register |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 4 | Register address |
| wdata_i | input | 8 | Register write data |
| rdata_o | output | 8 | Register read data for addr_i (combinational) |
| irq_ext_i | input | 8 | External IRQ lines, bit n = source n |
| int_src_i | input | 8 | Internal request lines, bit m = source 8+m |
| int_en_i | input | 8 | Per-source enables for the internal sources |
| mask_i | input | 3 | CPU interrupt mask level |
| req_o | output | 1 | Interrupt request to the CPU |
| req_idx_o | output | 4 | Number of the winning source |
| req_lvl_o | output | 3 | Level of the winning source |

## Verification
Corrupted state in a priority field or the enable register shows at the ports one clock later, in one of three ways: a wrong winner number, a wrong level, or a request that appears or vanishes against the mask. It also shows at once on a register read. The bench sweeps every source against every level and every mask value, so a field in the wrong position or an off-by-one in the mask compare fails within the first sweep. Pseudo-random stimulus, checked against an arithmetic model, then covers ties, disabled lines and standby clearing.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  localparam int LVL_W  = 3;
  localparam int REG_W  = 8;
  localparam int HI_LSB = 4;
  localparam int LO_LSB = 0;

  typedef logic [LVL_W-1:0] lvl_t;
endpackage

// File: rtl/irqc_regs.sv
module irqc_regs
  import irqc_pkg::*;
#(
  parameter int N_EXT  = 8,
  parameter int N_SRC  = 16,
  parameter int ADDR_W = 4
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    hw_stby_i,
  input  logic                    wr_en_i,
  input  logic [ADDR_W-1:0]       addr_i,
  input  logic [REG_W-1:0]        wdata_i,
  output logic [REG_W-1:0]        rdata_o,
  output logic [N_SRC-1:0][LVL_W-1:0] lvl_o,
  output logic [N_EXT-1:0]        en_o
);
  localparam int N_PREG  = N_SRC / 2;
  localparam int EN_ADDR = N_PREG;

  logic [N_EXT-1:0] en_q;

  for (genvar k = 0; k < N_PREG; k++) begin : g_preg
    lvl_t hi_q, lo_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        hi_q <= '0;
        lo_q <= '0;
      end else if (wr_en_i && addr_i == ADDR_W'(k)) begin
        hi_q <= wdata_i[HI_LSB +: LVL_W];
        lo_q <= wdata_i[LO_LSB +: LVL_W];
      end
    end
    assign lvl_o[2*k]   = hi_q;
    assign lvl_o[2*k+1] = lo_q;
  end

  // standby clear dominates software writes
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                         en_q <= '0;
    else if (hw_stby_i)                                  en_q <= '0;
    else if (wr_en_i && addr_i == ADDR_W'(EN_ADDR))      en_q <= wdata_i[N_EXT-1:0];
  end
  assign en_o = en_q;

  always_comb begin
    rdata_o = '0;
    for (int k = 0; k < N_PREG; k++) begin
      if (addr_i == ADDR_W'(k)) begin
        rdata_o[HI_LSB +: LVL_W] = lvl_o[2*k];
        rdata_o[LO_LSB +: LVL_W] = lvl_o[2*k+1];
      end
    end
    if (addr_i == ADDR_W'(EN_ADDR)) rdata_o[N_EXT-1:0] = en_q;
  end
endmodule

// File: rtl/irqc_pend.sv
module irqc_pend #(
  parameter int N_EXT = 8,
  parameter int N_INT = 8
) (
  input  logic [N_EXT-1:0]       irq_ext_i,
  input  logic [N_EXT-1:0]       ext_en_i,
  input  logic [N_INT-1:0]       int_src_i,
  input  logic [N_INT-1:0]       int_en_i,
  output logic [N_EXT+N_INT-1:0] pend_o
);
  for (genvar i = 0; i < N_EXT; i++) begin : g_ext
    assign pend_o[i] = irq_ext_i[i] & ext_en_i[i];
  end
  for (genvar m = 0; m < N_INT; m++) begin : g_int
    assign pend_o[N_EXT+m] = int_src_i[m] & int_en_i[m];
  end
endmodule

// File: rtl/irqc_arb.sv
module irqc_arb
  import irqc_pkg::*;
#(
  parameter int N_SRC = 16,
  parameter int IDX_W = 4
) (
  input  logic [N_SRC-1:0]            pend_i,
  input  logic [N_SRC-1:0][LVL_W-1:0] lvl_i,
  output logic                        found_o,
  output logic [IDX_W-1:0]            idx_o,
  output lvl_t                        lvl_o
);
  // scan from the top; >= lets a lower index replace an equal level
  always_comb begin
    found_o = 1'b0;
    idx_o   = '0;
    lvl_o   = '0;
    for (int i = N_SRC - 1; i >= 0; i--) begin
      if (pend_i[i] && (!found_o || lvl_i[i] >= lvl_o)) begin
        found_o = 1'b1;
        idx_o   = IDX_W'(i);
        lvl_o   = lvl_i[i];
      end
    end
  end
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
  import irqc_pkg::*;
#(
  parameter int N_EXT = 8,
  parameter int N_INT = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             hw_stby_i,
  input  logic             wr_en_i,
  input  logic [3:0]       addr_i,
  input  logic [7:0]       wdata_i,
  output logic [7:0]       rdata_o,
  input  logic [N_EXT-1:0] irq_ext_i,
  input  logic [N_INT-1:0] int_src_i,
  input  logic [N_INT-1:0] int_en_i,
  input  logic [2:0]       mask_i,
  output logic             req_o,
  output logic [3:0]       req_idx_o,
  output logic [2:0]       req_lvl_o
);
  localparam int N_SRC  = N_EXT + N_INT;
  localparam int IDX_W  = $clog2(N_SRC);
  localparam int ADDR_W = $clog2(N_SRC / 2 + 1);

  logic [N_SRC-1:0][LVL_W-1:0] lvl;
  logic [N_EXT-1:0]            en_q;
  logic [N_SRC-1:0]            pend;
  logic                        found, fire;
  logic [IDX_W-1:0]            win_idx;
  lvl_t                        win_lvl;

  irqc_regs #(.N_EXT(N_EXT), .N_SRC(N_SRC), .ADDR_W(ADDR_W)) u_regs (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .hw_stby_i(hw_stby_i),
    .wr_en_i  (wr_en_i),
    .addr_i   (addr_i),
    .wdata_i  (wdata_i),
    .rdata_o  (rdata_o),
    .lvl_o    (lvl),
    .en_o     (en_q)
  );

  irqc_pend #(.N_EXT(N_EXT), .N_INT(N_INT)) u_pend (
    .irq_ext_i(irq_ext_i),
    .ext_en_i (en_q),
    .int_src_i(int_src_i),
    .int_en_i (int_en_i),
    .pend_o   (pend)
  );

  irqc_arb #(.N_SRC(N_SRC), .IDX_W(IDX_W)) u_arb (
    .pend_i (pend),
    .lvl_i  (lvl),
    .found_o(found),
    .idx_o  (win_idx),
    .lvl_o  (win_lvl)
  );

  // strict compare: level 0 can never pass
  assign fire = found && (win_lvl > mask_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_o     <= 1'b0;
      req_idx_o <= '0;
      req_lvl_o <= '0;
    end else begin
      req_o     <= fire;
      req_idx_o <= fire ? win_idx : '0;
      req_lvl_o <= fire ? win_lvl : '0;
    end
  end
endmodule

// File: rtl/prio_irq_ctrl_chk.sv
module prio_irq_ctrl_chk #(
  parameter int N_EXT = 8,
  parameter int N_INT = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             hw_stby_i,
  input logic             wr_en_i,
  input logic [3:0]       addr_i,
  input logic [7:0]       rdata_o,
  input logic [N_EXT-1:0] irq_ext_i,
  input logic [2:0]       mask_i,
  input logic             req_o,
  input logic [3:0]       req_idx_o,
  input logic [2:0]       req_lvl_o,
  input logic [N_EXT-1:0] en_q
);
  localparam int N_PREG = (N_EXT + N_INT) / 2;

  logic [N_EXT-1:0] en_prev, irq_prev;
  logic             ext_ok;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_prev  <= '0;
      irq_prev <= '0;
    end else begin
      en_prev  <= en_q;
      irq_prev <= irq_ext_i;
    end
  end
  assign ext_ok = |((en_prev & irq_prev) & (N_EXT'(1) << req_idx_o));

  // R5
  lvl_above_mask_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_o |-> req_lvl_o > $past(mask_i));

  // R6
  idle_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_o |-> (req_idx_o == 4'd0 && req_lvl_o == 3'd0));

  // R7
  ext_enabled_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_o && req_idx_o < 4'(N_EXT)) |-> ext_ok);

  // R8
  stby_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hw_stby_i |=> en_q == '0);

  // R9
  en_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!hw_stby_i && !(wr_en_i && addr_i == 4'(N_PREG))) |=> $stable(en_q));

  // R1
  pad_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i < 4'(N_PREG)) |-> (!rdata_o[7] && !rdata_o[3]));
endmodule

bind prio_irq_ctrl prio_irq_ctrl_chk #(.N_EXT(N_EXT), .N_INT(N_INT)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .hw_stby_i(hw_stby_i),
  .wr_en_i  (wr_en_i),
  .addr_i   (addr_i),
  .rdata_o  (rdata_o),
  .irq_ext_i(irq_ext_i),
  .mask_i   (mask_i),
  .req_o    (req_o),
  .req_idx_o(req_idx_o),
  .req_lvl_o(req_lvl_o),
  .en_q     (en_q)
);

// File: tb/sim_prio_irq_ctrl.sv
`timescale 1ns/1ps
module sim_prio_irq_ctrl;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       hw_stby_i = 1'b0;
  logic       wr_en_i = 1'b0;
  logic [3:0] addr_i = '0;
  logic [7:0] wdata_i = '0;
  logic [7:0] rdata_o;
  logic [7:0] irq_ext_i = '0;
  logic [7:0] int_src_i = '0;
  logic [7:0] int_en_i = '0;
  logic [2:0] mask_i = '0;
  logic       req_o;
  logic [3:0] req_idx_o;
  logic [2:0] req_lvl_o;

  int total = 0;
  int fails = 0;
  logic [2:0] sh_lvl [16];
  logic [7:0] sh_en;
  logic [31:0] rs = 32'h1234_5678;

  always #2.5 clk_i = ~clk_i;

  prio_irq_ctrl u0 (.*);

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk_i);
    @(negedge clk_i);
  endtask

  task automatic wr(input int a, input int d);
    addr_i = 4'(a); wdata_i = 8'(d); wr_en_i = 1'b1;
    if (a < 8) begin
      sh_lvl[2*a]   = 3'((d >> 4) & 7);
      sh_lvl[2*a+1] = 3'(d & 7);
    end else if (a == 8 && !hw_stby_i) sh_en = 8'(d);
    step();
    wr_en_i = 1'b0;
  endtask

  task automatic rd(input int a, output int d);
    addr_i = 4'(a);
    #1;
    d = int'(rdata_o);
  endtask

  function automatic int sh_read(input int a);
    if (a < 8) return (int'(sh_lvl[2*a]) << 4) | int'(sh_lvl[2*a+1]);
    if (a == 8) return int'(sh_en);
    return 0;
  endfunction

  function automatic void model(output bit r, output int ix, output int lv);
    bit f = 0; int bl = 0; int bi = 0;
    for (int i = 0; i < 16; i++) begin
      bit p;
      p = (i < 8) ? (irq_ext_i[i] & sh_en[i]) : (int_src_i[i-8] & int_en_i[i-8]);
      if (p && (!f || int'(sh_lvl[i]) > bl)) begin f = 1; bl = int'(sh_lvl[i]); bi = i; end
    end
    r  = f && (bl > int'(mask_i));
    ix = r ? bi : 0;
    lv = r ? bl : 0;
  endfunction

  task automatic chk_model(input string tag);
    bit r; int ix, lv;
    model(r, ix, lv);
    chk(req_o == r, {tag, " req"}, int'(req_o), int'(r));
    chk(int'(req_idx_o) == ix, {tag, " idx"}, int'(req_idx_o), ix);
    chk(int'(req_lvl_o) == lv, {tag, " lvl"}, int'(req_lvl_o), lv);
  endtask

  task automatic chk_regs(input string tag);
    int d;
    for (int a = 0; a < 16; a++) begin
      rd(a, d);
      chk(d == sh_read(a), tag, d, sh_read(a));
    end
  endtask

  function automatic void nxt();
    rs = rs ^ (rs << 13);
    rs = rs ^ (rs >> 17);
    rs = rs ^ (rs << 5);
  endfunction

  initial begin
    repeat (200000) @(posedge clk_i);
    fails++; total++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    int d;
    for (int i = 0; i < 16; i++) sh_lvl[i] = '0;
    sh_en = '0;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    step();
    // R2 reset state
    chk(req_o == 1'b0 && req_idx_o == 0 && req_lvl_o == 0, "R2 outputs after reset",
        int'(req_o), 0);
    chk_regs("R2 register after reset");

    // R1 packing and padding
    wr(2, 8'hFF);
    rd(2, d); chk(d == 8'h77, "R1 padding bits read 0", d, 8'h77);
    wr(2, 8'h00);

    // R5/R3 exhaustive: every source x level x mask
    wr(8, 8'hFF);
    int_en_i = 8'hFF;
    for (int s = 0; s < 16; s++) begin
      irq_ext_i = (s < 8) ? 8'(1 << s) : 8'h00;
      int_src_i = (s >= 8) ? 8'(1 << (s - 8)) : 8'h00;
      for (int l = 0; l < 8; l++) begin
        wr(s >> 1, (s % 2 == 0) ? (l << 4) : l);
        for (int m = 0; m < 8; m++) begin
          mask_i = 3'(m);
          step();
          chk(req_o == (l > m), "R5 strict mask compare", int'(req_o), int'(l > m));
          chk(int'(req_idx_o) == ((l > m) ? s : 0), "R3 selected source", int'(req_idx_o),
              (l > m) ? s : 0);
          chk(int'(req_lvl_o) == ((l > m) ? l : 0), "R6 level or zero when idle",
              int'(req_lvl_o), (l > m) ? l : 0);
        end
      end
      wr(s >> 1, 0);
    end

    // R4 ties
    for (int k = 0; k < 8; k++) wr(k, 8'h55);
    irq_ext_i = 8'hFF; int_src_i = 8'hFF; int_en_i = 8'hFF; mask_i = 3'd0;
    step();
    chk(req_idx_o == 4'd0, "R4 tie lowest wins", int'(req_idx_o), 0);
    wr(3, 8'h65);
    step();
    chk(req_idx_o == 4'd6, "R3 higher level beats lower index", int'(req_idx_o), 6);
    irq_ext_i = 8'h00;
    step();
    chk(req_idx_o == 4'd8, "R4 tie among internal", int'(req_idx_o), 8);
    int_en_i = 8'hFE;
    step();
    chk(req_idx_o == 4'd9, "R4 tie after internal gate", int'(req_idx_o), 9);

    // R7 enable register
    int_src_i = 8'h00; irq_ext_i = 8'hFF;
    wr(8, 8'h00);
    step();
    chk(req_o == 1'b0, "R7 all lines disabled", int'(req_o), 0);
    wr(8, 8'h10);
    step();
    chk(req_idx_o == 4'd4 && req_o, "R7 only line 4 enabled", int'(req_idx_o), 4);
    irq_ext_i = 8'hEF;
    step();
    chk(req_o == 1'b0, "R7 enabled line low", int'(req_o), 0);

    // R6 one-cycle registered timing
    irq_ext_i = 8'hFF;
    step();
    irq_ext_i = 8'h00;
    #1;
    chk(req_o == 1'b1, "R6 output holds until edge", int'(req_o), 1);
    step();
    chk(req_o == 1'b0, "R6 output updates after edge", int'(req_o), 0);

    // R8 hardware standby
    wr(8, 8'hA5);
    rd(8, d); chk(d == 8'hA5, "R7 enable readback", d, 8'hA5);
    hw_stby_i = 1'b1;
    step();
    sh_en = 8'h00;
    rd(8, d); chk(d == 0, "R8 standby clears enable", d, 0);
    wr(8, 8'hFF);
    rd(8, d); chk(d == 0, "R8 write ignored in standby", d, 0);
    rd(0, d); chk(d == sh_read(0), "R8 priority kept in standby", d, sh_read(0));
    hw_stby_i = 1'b0;
    step();
    rd(8, d); chk(d == 0, "R8 enable stays clear after standby", d, 0);

    // R9 retention, R10 unmapped
    wr(8, 8'h3C);
    for (int i = 0; i < 20; i++) begin
      irq_ext_i = 8'(i * 37); int_src_i = 8'(i * 11);
      if (i % 3 == 0) wr(9 + (i % 7), 8'hFF);
      else if (i % 3 == 1) wr(i % 8, i * 13);
      else step();
    end
    rd(8, d); chk(d == 8'h3C, "R9 enable retained", d, 8'h3C);
    chk_regs("R10 unmapped writes change nothing");

    // R3/R4/R5 pseudo-random against model
    for (int i = 0; i < 400; i++) begin
      nxt();
      if (rs[3:2] != 2'b00) wr(int'(rs[11:8]), int'(rs[19:12]));
      nxt();
      irq_ext_i = rs[7:0]; int_src_i = rs[15:8]; int_en_i = rs[23:16]; mask_i = rs[26:24];
      step();
      chk_model("R3 random");
      if (i % 50 == 0) chk_regs("R1 random readback");
    end

    // R2 reset mid-run
    rst_ni = 1'b0;
    #1;
    for (int i = 0; i < 16; i++) sh_lvl[i] = '0;
    sh_en = '0;
    chk(req_o == 1'b0, "R2 async reset clears req", int'(req_o), 0);
    chk_regs("R2 registers after second reset");
    step();
    rst_ni = 1'b1;
    step();

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule